// File: doc/BRIEF.md
# Diagnostic SRAM Access Port

This block gives a host a register-level slave path for reading and writing the packet SRAM one 16-bit word at a time, for diagnostic use. The host loads a 4-bit upper address field and a 16-bit lower address field. The upper-field register also holds a select bit that chooses between SRAM and boot-ROM space. The host then reads or writes a data register. The SRAM is slow and runs on its own timing, so a data read is never answered on the spot. The first read launches a fetch in the background and receives a retry. Later reads also receive retries until the fetched word has been captured, and then one read returns it.

Access is permitted only while the controller is stopped, or while it is suspended with fast suspend disabled. In any other state, and whenever ROM space is selected, data-port accesses complete without touching the SRAM. Each host request gets exactly one response, either an ack or a retry, one cycle after the request.

Top module: `sram_diag_port`

## Requirements
- R1: Writing register 0 loads the upper address from wdata[3:0] and the select bit from wdata[15]. Writing register 1 loads the lower address. Both registers read back with ack, and sram_addr presents {upper, lower} as a 20-bit word address.
- R2: When the select bit is 1 (ROM space), a data-port read acks with zero and a data-port write is acked and dropped, with no SRAM request.
- R3: In the permitted state with the select bit 0 and no captured word, a data-port read (register 2) returns a retry and starts a fetch: sram_req is high with sram_we low.
- R4: The fetch holds sram_req for FETCH_WAIT cycles and captures sram_rdata on the last of them. With back-to-back reads, FETCH_WAIT+1 retries are returned and the next read acks with the memory word. Delivering the word consumes it.
- R5: A permitted data-port write is acked and posts exactly one SRAM write cycle that carries the full 16-bit word.
- R6: Access is permitted when ctl_stopped is 1, or when ctl_suspended is 1 and ctl_fast_susp is 0.
- R7: Outside the permitted state, data reads ack with zero, writes are dropped, any running fetch is aborted, and sram_req is low from the next cycle onward.
- R8: Writing either address register clears the captured word and aborts a running fetch. This holds even when the write lands in the cycle in which the fetch completes.
- R9: Every request gets exactly one of ack or retry, one cycle later and never both. A data write during a fetch is retried. Register 3 acks with zero.
- R10: After reset, host_ack, host_retry, sram_req, sram_we and sram_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register select: 0 upper/select, 1 lower, 2 data, 3 unused |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | Access completed |
| host_retry | output | 1 | Access must be repeated |
| host_rdata | output | 16 | Read data, valid with host_ack |
| ctl_stopped | input | 1 | Controller is stopped |
| ctl_suspended | input | 1 | Controller is suspended |
| ctl_fast_susp | input | 1 | Fast suspend enabled |
| sram_req | output | 1 | SRAM cycle active |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | 20 | SRAM word address |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data |

## Verification
Fetch completion and an address-register write can fall in the same cycle. The bench provokes this by issuing a data read and then idling FETCH_WAIT-1 cycles, so that the lower-address write lands on the capture edge. The captured word must be discarded. This is judged by requiring the next data read to retry again, and the full retry count that follows to return the word at the new address from the bench's memory model.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    typedef enum logic [1:0] {
        REG_UPPER = 2'd0,
        REG_LOWER = 2'd1,
        REG_DATA  = 2'd2,
        REG_SPARE = 2'd3
    } sdp_reg_e;
endpackage

// File: rtl/sdp_mode_gate.sv
module sdp_mode_gate (
    input  logic stopped,
    input  logic suspended,
    input  logic fast_susp,
    output logic allowed
);
    always_comb begin
        allowed = stopped | (suspended & ~fast_susp);
    end
endmodule

// File: rtl/sdp_fetch_timer.sv
module sdp_fetch_timer #(
    parameter int WAIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CW = (WAIT > 1) ? $clog2(WAIT) : 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic last;

    always_comb begin
        last = t_q.busy && (t_q.cnt == CW'(WAIT - 1));
        t_d  = t_q;
        if (abort) begin
            t_d.busy = 1'b0;
        end else if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = '0;
        end else if (t_q.busy) begin
            if (last) t_d.busy = 1'b0;
            else      t_d.cnt  = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;
    assign done = last;

    p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !t_q.busy);
endmodule

// File: rtl/sram_diag_port.sv
module sram_diag_port #(
    parameter int ADDR_HI_W  = 4,
    parameter int ADDR_LO_W  = 16,
    parameter int DATA_W     = 16,
    parameter int FETCH_WAIT = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_req,
    input  logic                         host_we,
    input  logic [1:0]                   host_reg,
    input  logic [DATA_W-1:0]            host_wdata,
    output logic                         host_ack,
    output logic                         host_retry,
    output logic [DATA_W-1:0]            host_rdata,
    input  logic                         ctl_stopped,
    input  logic                         ctl_suspended,
    input  logic                         ctl_fast_susp,
    output logic                         sram_req,
    output logic                         sram_we,
    output logic [ADDR_HI_W+ADDR_LO_W-1:0] sram_addr,
    output logic [DATA_W-1:0]            sram_wdata,
    input  logic [DATA_W-1:0]            sram_rdata
);
    import sdp_pkg::*;

    localparam int SEL_BIT = DATA_W - 1;

    typedef struct packed {
        logic [ADDR_HI_W-1:0] hi;
        logic                 rom;
        logic [ADDR_LO_W-1:0] lo;
        logic                 valid;
        logic [DATA_W-1:0]    word;
        logic                 ack;
        logic                 retry;
        logic [DATA_W-1:0]    rdata;
        logic                 wr;
        logic [DATA_W-1:0]    wdata;
    } st_t;

    st_t  st_d, st_q;
    logic allowed;
    logic f_start, f_abort, f_busy, f_done;
    sdp_reg_e sel;

    sdp_mode_gate u_gate (
        .stopped   (ctl_stopped),
        .suspended (ctl_suspended),
        .fast_susp (ctl_fast_susp),
        .allowed   (allowed)
    );

    sdp_fetch_timer #(.WAIT(FETCH_WAIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (f_start),
        .abort (f_abort),
        .busy  (f_busy),
        .done  (f_done)
    );

    always_comb begin
        sel      = sdp_reg_e'(host_reg);
        st_d     = st_q;
        st_d.ack = 1'b0;
        st_d.retry = 1'b0;
        st_d.rdata = '0;
        st_d.wr    = 1'b0;
        f_start  = 1'b0;
        f_abort  = ~allowed;
        if (host_req) begin
            case (sel)
                REG_UPPER: begin
                    st_d.ack = 1'b1;
                    st_d.rdata[SEL_BIT] = st_q.rom;
                    st_d.rdata[ADDR_HI_W-1:0] = st_q.hi;
                    if (host_we) begin
                        st_d.hi    = host_wdata[ADDR_HI_W-1:0];
                        st_d.rom   = host_wdata[SEL_BIT];
                        st_d.valid = 1'b0;
                        f_abort    = 1'b1;
                    end
                end
                REG_LOWER: begin
                    st_d.ack   = 1'b1;
                    st_d.rdata = DATA_W'(st_q.lo);
                    if (host_we) begin
                        st_d.lo    = host_wdata[ADDR_LO_W-1:0];
                        st_d.valid = 1'b0;
                        f_abort    = 1'b1;
                    end
                end
                REG_DATA: begin
                    if (!allowed || st_q.rom) begin
                        st_d.ack = 1'b1;
                    end else if (host_we) begin
                        if (f_busy) begin
                            st_d.retry = 1'b1;
                        end else begin
                            st_d.ack   = 1'b1;
                            st_d.wr    = 1'b1;
                            st_d.wdata = host_wdata;
                            st_d.valid = 1'b0;
                        end
                    end else if (st_q.valid) begin
                        st_d.ack   = 1'b1;
                        st_d.rdata = st_q.word;
                        st_d.valid = 1'b0;
                    end else begin
                        st_d.retry = 1'b1;
                        f_start    = ~f_busy;
                    end
                end
                default: st_d.ack = 1'b1;
            endcase
        end
        if (f_done && !f_abort) begin
            st_d.valid = 1'b1;
            st_d.word  = sram_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_ack   = st_q.ack;
    assign host_retry = st_q.retry;
    assign host_rdata = st_q.rdata;
    assign sram_req   = st_q.wr | f_busy;
    assign sram_we    = st_q.wr;
    assign sram_addr  = {st_q.hi, st_q.lo};
    assign sram_wdata = st_q.wdata;

    p_one_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ack && host_retry));
    p_resp_has_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack || host_retry) |-> $past(host_req));
    p_no_touch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !allowed |=> !sram_req);
    p_first_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we && host_reg == REG_DATA && allowed && !st_q.rom && !st_q.valid)
        |=> host_retry);
    p_blocked_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_reg == REG_DATA && !allowed) |=> (host_ack && host_rdata == '0));
    p_addr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && (host_reg == REG_UPPER || host_reg == REG_LOWER)) |=> !st_q.valid);
    p_write_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> $past(host_req && host_we && host_reg == REG_DATA));
endmodule

// File: tb/sram_diag_port_tb.sv
module sram_diag_port_tb_top;
    localparam int WAIT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [1:0]  host_reg = 2'd0;
    logic [15:0] host_wdata = '0;
    logic        host_ack, host_retry;
    logic [15:0] host_rdata;
    logic        ctl_stopped = 1'b1, ctl_suspended = 1'b0, ctl_fast_susp = 1'b0;
    logic        sram_req, sram_we;
    logic [19:0] sram_addr;
    logic [15:0] sram_wdata, sram_rdata;

    logic [15:0] mem [256];
    int          wr_count = 0;
    int          tests = 0, fails = 0, cycles = 0;
    logic        r_ack, r_retry;
    logic [15:0] r_data;

    always #4 clk = ~clk;

    sram_diag_port #(.FETCH_WAIT(WAIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_reg(host_reg), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_retry(host_retry), .host_rdata(host_rdata),
        .ctl_stopped(ctl_stopped), .ctl_suspended(ctl_suspended),
        .ctl_fast_susp(ctl_fast_susp), .sram_req(sram_req), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    assign sram_rdata = mem[sram_addr[7:0]];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (sram_req && sram_we) begin
            mem[sram_addr[7:0]] <= sram_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] r, input logic w, input logic [15:0] d);
        host_req = 1'b1; host_reg = r; host_we = w; host_wdata = d;
        @(negedge clk);
        r_ack = host_ack; r_retry = host_retry; r_data = host_rdata;
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_word(output int retries, output logic [15:0] d);
        retries = 0;
        d = '0;
        for (int i = 0; i < 40; i++) begin
            op(2'd2, 1'b0, 16'h0);
            if (r_ack) begin d = r_data; break; end
            if (r_retry) retries++;
        end
    endtask

    // {reg, we, wdata, ack, retry, rdata}
    localparam logic [36:0] VEC [9] = '{
        {2'd0, 1'b1, 16'h8005, 1'b1, 1'b0, 16'h0000},
        {2'd0, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h8005},
        {2'd1, 1'b1, 16'h1234, 1'b1, 1'b0, 16'h0000},
        {2'd1, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h1234},
        {2'd2, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000},
        {2'd2, 1'b1, 16'h5555, 1'b1, 1'b0, 16'h0000},
        {2'd0, 1'b1, 16'h0003, 1'b1, 1'b0, 16'h8005},
        {2'd0, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0003},
        {2'd3, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000}
    };

    initial begin
        int          n;
        logic [15:0] d;
        for (int i = 0; i < 256; i++) mem[i] = 16'hC0DE ^ 16'(i * 257);
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!host_ack && !host_retry && !sram_req && !sram_we && sram_addr == '0,
            "R10 reset state", {sram_req, sram_we, host_ack, host_retry}, 0);

        for (int v = 0; v < 9; v++) begin
            op(VEC[v][36:35], VEC[v][34], VEC[v][33:18]);
            chk(r_ack == VEC[v][17] && r_retry == VEC[v][16] && r_data == VEC[v][15:0],
                $sformatf("R1/R2/R9 vector %0d", v), {r_ack, r_retry, r_data},
                {VEC[v][17], VEC[v][16], VEC[v][15:0]});
        end
        chk(wr_count == 0, "R2 ROM write dropped", wr_count, 0);
        chk(sram_addr == 20'h31234, "R1 address composition", sram_addr, 20'h31234);

        op(2'd2, 1'b0, 16'h0);
        chk(r_retry && !r_ack, "R3 first read retries", {r_ack, r_retry}, 1);
        chk(sram_req && !sram_we, "R3 fetch started", {sram_req, sram_we}, 2);
        read_word(n, d);
        chk(n == WAIT, "R4 further retries", n, WAIT);
        chk(d == mem[8'h34], "R4 fetched word", d, mem[8'h34]);

        op(2'd0, 1'b1, 16'h0000);
        op(2'd1, 1'b1, 16'h0010);
        op(2'd2, 1'b1, 16'hBEEF);
        chk(r_ack, "R5 write acked", r_ack, 1);
        idle(2);
        chk(wr_count == 1 && mem[8'h10] == 16'hBEEF, "R5 single word write", mem[8'h10], 16'hBEEF);
        read_word(n, d);
        chk(n == WAIT + 1 && d == 16'hBEEF, "R4 readback after write", {n[15:0], d}, {16'(WAIT + 1), 16'hBEEF});

        ctl_stopped = 1'b0; ctl_suspended = 1'b1; ctl_fast_susp = 1'b1;
        op(2'd2, 1'b0, 16'h0);
        chk(r_ack && r_data == 0, "R7 blocked read zero", r_data, 0);
        op(2'd2, 1'b1, 16'h1111);
        idle(2);
        chk(wr_count == 1 && mem[8'h10] == 16'hBEEF, "R7 blocked write dropped", wr_count, 1);
        ctl_fast_susp = 1'b0;
        op(2'd2, 1'b0, 16'h0);
        chk(r_retry, "R6 non-fast suspend allowed", r_retry, 1);
        read_word(n, d);
        chk(d == 16'hBEEF, "R6 suspend read data", d, 16'hBEEF);

        ctl_suspended = 1'b0; ctl_stopped = 1'b1;
        op(2'd2, 1'b0, 16'h0);
        op(2'd2, 1'b1, 16'h2222);
        chk(r_retry && wr_count == 1, "R9 write during fetch retried", r_retry, 1);
        ctl_stopped = 1'b0;
        @(negedge clk);
        chk(!sram_req, "R7 fetch aborted", sram_req, 0);
        op(2'd2, 1'b0, 16'h0);
        chk(r_ack && r_data == 0, "R7 read while running", r_data, 0);
        ctl_stopped = 1'b1;
        op(2'd2, 1'b0, 16'h0);
        chk(r_retry, "R7 aborted fetch restarts", r_retry, 1);
        read_word(n, d);

        op(2'd2, 1'b0, 16'h0);
        idle(WAIT - 1);
        op(2'd1, 1'b1, 16'h0020);
        op(2'd2, 1'b0, 16'h0);
        chk(r_retry, "R8 capture dropped on address write", r_retry, 1);
        read_word(n, d);
        chk(n == WAIT && d == mem[8'h20], "R8 new address word", d, mem[8'h20]);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule